// File: doc/BRIEF.md
# Presettable Two-Digit Up/Down Decimal Counter (00 to 63)

This block keeps a count between decimal 00 and 63. The count is held as two BCD digits, a tens digit and a units digit, so a display can show them directly. While the run input is high, the count moves one step up or one step down on each pulse of an internal enable. The direction input selects the way it moves. The enable comes from a 3-bit prescaler that runs freely on the main clock. The prescaler fires once every 8 clocks. No derived clock is used anywhere: every register runs on `clk`, and the enable acts only as a qualifier.

A 6-bit binary preset input is watched all the time. When its value differs from the last preset the block took, the new value is converted to two BCD digits with the shift-and-add-3 method and loaded into the count. The new preset is also stored, so the same value is not taken again. If a count step and a preset change arrive in the same cycle, the count step wins. The load then happens in the following cycle.

The interfaces are plain control and data pins with no handshake. The preset is sampled like a level, not like a stream. The display sees the digits for as long as they are held.

Top module: `bcd64_counter`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets both digits to 0, clears the prescaler and sets the stored preset to 0. After reset is released, the first count step can happen only at the 8th rising edge.
- R2: The outputs are always a valid decimal value from 00 to 63: `tens_o` is at most 6, `units_o` is at most 9, and when `tens_o` is 6, `units_o` is at most 3.
- R3: The count steps only at an edge where the prescaler has all three bits at 1 and `run_i` is 1. That is every 8th edge after reset. With `run_i` at 0 and the preset unchanged, the digits hold.
- R4: A step with `up_i` = 1 adds one to the count. When the units digit is 9, the units become 0 and the tens digit goes up by one.
- R5: Counting up from 63 gives 00.
- R6: A step with `up_i` = 0 subtracts one from the count. When the units digit is 0 and the tens digit is not 0, the units become 9 and the tens digit goes down by one.
- R7: Counting down from 00 gives 63.
- R8: When `preset_i` differs from the stored preset at an edge with no count step, that edge loads the BCD form of `preset_i` into the digits and stores `preset_i` as the new stored preset.
- R9: A preset value that equals the stored preset causes no load, so counting continues from the current count.
- R10: When a count step and a preset change come at the same edge, only the step happens at that edge. The pending load is taken at the next edge, and that edge has no step.
- R11: The conversion is correct for every preset from 0 to 63: tens = value / 10 and units = value % 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock; every register uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | Enables counting when 1 |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| preset_i | input | 6 | Binary preset value; a change triggers a load |
| tens_o | output | 4 | Tens BCD digit of the count |
| units_o | output | 4 | Units BCD digit of the count |

## Verification
The bench counts fully round in both directions. A design that got either wrap wrong would move from 63 to 64 or from 00 to 99, or would jump at the x9 and x0 digit borders. It sweeps all 64 preset values with the counter stopped. A faulty shift-and-add-3 converter would show a wrong digit for values such as 10, 19 or 59. It also lines preset changes up with the exact edge where the prescaler fires. A design with the wrong priority would drop the step or lose the load. A design that used a wrong prescaler period would move the step away from the edge that the reference model predicts, on every clock.

// File: rtl/bcd64_pkg.sv
package bcd64_pkg;
  // Largest count value; the digit limits below follow from it.
  localparam int unsigned CNT_MAX  = 63;
  localparam int unsigned PRESET_W = $clog2(CNT_MAX + 1);
  localparam int unsigned DIGITS   = 2;
  localparam int unsigned PRE_W    = 3;

  localparam logic [3:0] TOP_TENS  = 4'(CNT_MAX / 10);
  localparam logic [3:0] TOP_UNITS = 4'(CNT_MAX % 10);
  localparam logic [3:0] DIGIT_MAX = 4'd9;

  typedef struct packed {
    logic [3:0] tens;
    logic [3:0] units;
  } bcd2_t;

  localparam bcd2_t BCD_ZERO = '{tens: 4'd0, units: 4'd0};
  localparam bcd2_t BCD_TOP  = '{tens: TOP_TENS, units: TOP_UNITS};
endpackage

// File: rtl/bcd64_prescaler.sv
module bcd64_prescaler #(
  parameter int unsigned W = 3
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  logic [W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  assign tick_o = &div_q;

  // R3: the enable is a single-cycle pulse, never two in a row
  a_r3_tick_isolated: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

  // R1: the cycle after reset the enable is low
  a_r1_tick_low_after_reset: assert property (@(posedge clk)
    rst |=> !tick_o);
endmodule

// File: rtl/bcd64_bin2bcd.sv
module bcd64_bin2bcd #(
  parameter int unsigned BIN_W  = 6,
  parameter int unsigned DIGITS = 2
) (
  input  logic [BIN_W-1:0]    bin_i,
  output logic [4*DIGITS-1:0] bcd_o
);
  localparam int unsigned WORK_W = BIN_W + 4 * DIGITS;

  // Clear, place the value low, then per bit: adjust fields >= 5 by 3, shift left.
  function automatic logic [4*DIGITS-1:0] dabble(input logic [BIN_W-1:0] v);
    logic [WORK_W-1:0] w;
    w = '0;
    w[BIN_W-1:0] = v;
    for (int it = 0; it < BIN_W; it++) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (w[BIN_W + 4*d +: 4] >= 4'd5)
          w[BIN_W + 4*d +: 4] = w[BIN_W + 4*d +: 4] + 4'd3;
      end
      w = w << 1;
    end
    return w[WORK_W-1 -: 4*DIGITS];
  endfunction

  assign bcd_o = dabble(bin_i);

  // R11: every digit produced is a decimal digit
  always_comb begin
    if (!$isunknown(bin_i)) begin
      for (int d = 0; d < DIGITS; d++) begin
        a_r11_digit_decimal: assert (bcd_o[4*d +: 4] <= 4'd9);
      end
    end
  end
endmodule

// File: rtl/bcd64_step.sv
module bcd64_step
  import bcd64_pkg::*;
(
  input  bcd2_t cur_i,
  input  logic  up_i,
  output bcd2_t nxt_o
);
  logic at_top, at_zero;

  assign at_top  = (cur_i == BCD_TOP);
  assign at_zero = (cur_i == BCD_ZERO);

  always_comb begin
    nxt_o = cur_i;
    if (up_i) begin
      if (at_top) begin
        nxt_o = BCD_ZERO;
      end else if (cur_i.units == DIGIT_MAX) begin
        nxt_o.units = 4'd0;
        nxt_o.tens  = cur_i.tens + 4'd1;
      end else begin
        nxt_o.units = cur_i.units + 4'd1;
      end
    end else begin
      if (at_zero) begin
        nxt_o = BCD_TOP;
      end else if (cur_i.units == 4'd0) begin
        nxt_o.units = DIGIT_MAX;
        nxt_o.tens  = cur_i.tens - 4'd1;
      end else begin
        nxt_o.units = cur_i.units - 4'd1;
      end
    end
  end
endmodule

// File: rtl/bcd64_counter.sv
module bcd64_counter
  import bcd64_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                run_i,
  input  logic                up_i,
  input  logic [PRESET_W-1:0] preset_i,
  output logic [3:0]          tens_o,
  output logic [3:0]          units_o
);
  logic                tick;
  logic                adv;
  logic                load_req;
  logic [PRESET_W-1:0] prev_q;
  bcd2_t               cnt_q;
  bcd2_t               step_nxt;
  bcd2_t               conv;

  bcd64_prescaler #(.W(PRE_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  bcd64_step u_step (
    .cur_i (cnt_q),
    .up_i  (up_i),
    .nxt_o (step_nxt)
  );

  bcd64_bin2bcd #(.BIN_W(PRESET_W), .DIGITS(DIGITS)) u_conv (
    .bin_i (preset_i),
    .bcd_o (conv)
  );

  assign adv      = tick & run_i;
  assign load_req = (preset_i != prev_q);

  // Step beats load; a deferred load is taken on the next edge (no tick there).
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= BCD_ZERO;
      prev_q <= '0;
    end else if (adv) begin
      cnt_q  <= step_nxt;
    end else if (load_req) begin
      cnt_q  <= conv;
      prev_q <= preset_i;
    end
  end

  assign tens_o  = cnt_q.tens;
  assign units_o = cnt_q.units;

  // R2: count stays a decimal value within 00..63
  a_r2_in_range: assert property (@(posedge clk) disable iff (rst)
    (cnt_q.units <= DIGIT_MAX) && (cnt_q.tens <= TOP_TENS) &&
    !((cnt_q.tens == TOP_TENS) && (cnt_q.units > TOP_UNITS)));

  // R5: up from the top wraps to zero
  a_r5_up_wrap: assert property (@(posedge clk) disable iff (rst)
    (adv && up_i && cnt_q == BCD_TOP) |=> (cnt_q == BCD_ZERO));

  // R7: down from zero wraps to the top
  a_r7_down_wrap: assert property (@(posedge clk) disable iff (rst)
    (adv && !up_i && cnt_q == BCD_ZERO) |=> (cnt_q == BCD_TOP));

  // R3 / R9: no step and no preset change leaves the count alone
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!adv && !load_req) |=> $stable(cnt_q));

  // R8: a load stores the preset it took
  a_r8_load_stores: assert property (@(posedge clk) disable iff (rst)
    (!adv && load_req) |=> (prev_q == $past(preset_i)));

  // R10: a load held back by a step is followed by an edge without a step
  a_r10_deferred_load: assert property (@(posedge clk) disable iff (rst)
    (adv && load_req) |=> !adv);
endmodule

// File: tb/bcd64_counter_tb_top.sv
module bcd64_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run_i = 1'b0;
  logic       up_i = 1'b1;
  logic [5:0] preset_i = 6'd0;
  logic [3:0] tens_o, units_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  int    m_pc = 0;
  int    m_val = 0;
  int    m_prev = 0;
  string m_tag = "R1";

  bcd64_counter dut_i (
    .clk      (clk),
    .rst      (rst),
    .run_i    (run_i),
    .up_i     (up_i),
    .preset_i (preset_i),
    .tens_o   (tens_o),
    .units_o  (units_o)
  );

  always #4 clk = ~clk;

  // behavioural model, updated on each rising edge from inputs set at the negedge
  always @(posedge clk) begin
    bit tk;
    cycles++;
    if (rst) begin
      m_pc = 0; m_val = 0; m_prev = 0; m_tag = "R1";
    end else begin
      tk = (m_pc == 7);
      m_pc = (m_pc + 1) % 8;
      if (run_i && tk) begin
        if (int'(preset_i) != m_prev) m_tag = "R10";
        else if (up_i) m_tag = (m_val == 63) ? "R5" : "R4";
        else m_tag = (m_val == 0) ? "R7" : "R6";
        if (up_i) m_val = (m_val == 63) ? 0 : m_val + 1;
        else      m_val = (m_val == 0) ? 63 : m_val - 1;
      end else if (int'(preset_i) != m_prev) begin
        m_tag = (m_tag == "R10") ? "R10" : "R8";
        m_prev = int'(preset_i);
        m_val = m_prev;
      end else begin
        m_tag = "R3 R9";
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (cycles > 0) begin
      check(m_tag, int'(tens_o) * 10 + int'(units_o), m_val);
      checks++;
      if (tens_o > 4'd6 || units_o > 4'd9 || (tens_o == 4'd6 && units_o > 4'd3)) begin
        errors++;
        $display("FAIL R2: actual %0d/%0d expected a value within 00..63", tens_o, units_o);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(tens_o) * 10 + int'(units_o), 0);
    rst = 1'b0;
    // R3: run low, count must hold
    repeat (40) @(negedge clk);
    // R4 R5: full upward cycle through the wrap
    run_i = 1'b1; up_i = 1'b1;
    repeat (600) @(negedge clk);
    // R6 R7: full downward cycle through the wrap
    up_i = 1'b0;
    repeat (600) @(negedge clk);
    // R8 R11: sweep every preset with counting stopped
    run_i = 1'b0;
    for (int v = 0; v < 64; v++) begin
      preset_i = 6'(63 - v);
      repeat (2) @(negedge clk);
      check("R11", int'(tens_o) * 10 + int'(units_o), 63 - v);
    end
    // R9: unchanged preset while counting
    run_i = 1'b1; up_i = 1'b1;
    repeat (100) @(negedge clk);
    // R10: preset change on the exact edge the prescaler fires
    for (int k = 0; k < 6; k++) begin
      do @(negedge clk); while (m_pc != 7);
      preset_i = 6'(k * 11 + 5);
      up_i = k[0];
      @(negedge clk);
      @(negedge clk);
      check("R10", int'(tens_o) * 10 + int'(units_o), k * 11 + 5);
    end
    // R1: reset in the middle of a run
    rst = 1'b1;
    @(negedge clk);
    check("R1", int'(tens_o) * 10 + int'(units_o), 0);
    rst = 1'b0;
    preset_i = 6'd0;
    repeat (20) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule